// File: doc/BRIEF.md
# Byte-Coded Register Machine Core

This block is a small multicycle processor. It executes a stream of instruction bytes of varying length out of its own program memory. It has four 16-bit general-purpose registers, a program counter and an instruction register. Each instruction starts with an opcode byte, and the opcode fixes how many operand bytes follow. There are six operations: a no-op, a load of an immediate byte, register add, register subtract, an absolute jump, and a conditional skip when two registers are equal.

The program counter advances before every byte it reads. Bytes therefore sit at addresses 1 and up, while the counter resets to 0. A jump loads its raw address byte, so execution resumes at the byte after the target. An equal comparison adds a fixed 3 to the counter after the comparison's operands have been read. Before each opcode fetch the core compares the counter with the program length, which is a configuration input. Once the counter is no longer below that length, the core halts.

Before a run, a host writes the program through a byte-wide load port. A `start` pulse then launches execution. Every completed instruction produces a one-cycle `retire` strobe. While the strobe is high, the debug outputs show the counter, the opcode and all four registers, so a run can be compared against a reference trace.

Top module: `bytevm_core`

## Requirements
- R1: After reset, `halted`, `illegal` and `retire` are low, `dbg_pc` is 0 and all registers are 0. The core then stays idle, with no retire strobe, until `start` is pulsed.
- R2: A `start` pulse clears the PC, the registers, `halted` and `illegal`. In the following cycle `dbg_pc` reads 0. Every byte read first increments the PC, so the first opcode comes from address 1.
- R3: Opcode 0x01 is a 3-byte load. The first operand byte selects the destination register (0x00=A, 0x01=B, 0x02=C, 0x03=D). The second operand byte is zero-extended to 16 bits and written to that register.
- R4: Opcodes 0x02 (add) and 0x03 (subtract) are 3 bytes long. Each writes `dst op src` into the first-named register, using the register encoding of R3, and wraps modulo 2^16.
- R5: Opcode 0x04 is a 2-byte jump. It loads the PC with its address byte, so the next opcode is fetched from that address plus 1.
- R6: Opcode 0x05 is a 3-byte compare-and-skip on two registers. If the two registers are equal, the PC advances by a further 3 after the operands are read. Otherwise the PC is left where it is.
- R7: Opcode 0x00 is a 1-byte no-op that leaves every register unchanged.
- R8: Before each opcode fetch, if `dbg_pc` >= `prog_len`, `halted` rises and stays high until the next `start`, and no further retire strobe follows. With `prog_len` 0 the core halts without retiring anything.
- R9: An opcode above 0x05 is a 1-byte no-op and sets the sticky `illegal` flag. For opcodes 0x01, 0x02, 0x03 and 0x05, a register operand byte above 0x03 still consumes all 3 bytes. The instruction then writes no register, skips nothing, and sets `illegal`.
- R10: `retire` is a one-cycle pulse for each completed instruction. While it is high, `dbg_pc`, `dbg_ir` and the register outputs show the state after that instruction. Two retire pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear state and begin execution |
| prog_len | input | ADDR_W | Program length in bytes (last valid address) |
| load_we | input | 1 | Program memory write enable |
| load_addr | input | ADDR_W | Program memory write address |
| load_byte | input | 8 | Program memory write data |
| halted | output | 1 | Stop condition reached |
| illegal | output | 1 | Sticky undefined opcode/operand flag |
| retire | output | 1 | One-cycle strobe per completed instruction |
| dbg_pc | output | ADDR_W | Program counter |
| dbg_ir | output | 8 | Last opcode byte |
| dbg_reg_a | output | DATA_W | Register A |
| dbg_reg_b | output | DATA_W | Register B |
| dbg_reg_c | output | DATA_W | Register C |
| dbg_reg_d | output | DATA_W | Register D |

## Verification
The halt-entry property assumes that `prog_len` stays constant from `start` until `halted` rises. The properties also assume that the load port is not used while a program is running. The bench writes each program image and sets the length while the core is idle or halted, and changes neither again until it has seen `halted`. Every program it runs either terminates through a forward jump, a skip, or a loop whose exit the reference model reaches. No run depends on the counter wrapping past the top of memory.

// File: rtl/bytevm_pkg.sv
package bytevm_pkg;

  localparam int BYTE_W    = 8;
  localparam int NUM_GPR   = 4;
  localparam int GPR_SEL_W = $clog2(NUM_GPR);

  typedef enum logic [BYTE_W-1:0] {
    OP_NOP = 8'h00,
    OP_LDI = 8'h01,
    OP_ADD = 8'h02,
    OP_SUB = 8'h03,
    OP_JMP = 8'h04,
    OP_SKE = 8'h05
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_OPCODE,
    ST_OPND1,
    ST_OPND2,
    ST_HALT
  } state_e;

  function automatic logic opcode_known(input logic [BYTE_W-1:0] b);
    return b <= OP_SKE;
  endfunction

  function automatic logic gpr_code_ok(input logic [BYTE_W-1:0] b);
    return b < BYTE_W'(NUM_GPR);
  endfunction

endpackage

// File: rtl/bytevm_progmem.sv
module bytevm_progmem #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] store [DEPTH];

  // single write port, registered read port: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    rd_q <= store[rd_addr];
  end

endmodule

// File: rtl/bytevm_regfile.sv
module bytevm_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [$clog2(NREG)-1:0] rd_sel_a,
  input  logic [$clog2(NREG)-1:0] rd_sel_b,
  output logic [DATA_W-1:0]      rd_a,
  output logic [DATA_W-1:0]      rd_b,
  output logic [NREG*DATA_W-1:0] flat_q
);
  logic [DATA_W-1:0] gpr [NREG];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < NREG; i++) gpr[i] <= '0;
    end else if (wr_en) begin
      gpr[wr_sel] <= wr_data;
    end
  end

  assign rd_a = gpr[rd_sel_a];
  assign rd_b = gpr[rd_sel_b];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign flat_q[g*DATA_W +: DATA_W] = gpr[g];
  end

endmodule

// File: rtl/bytevm_alu.sv
module bytevm_alu
  import bytevm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [BYTE_W-1:0] op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [BYTE_W-1:0] imm,
  output logic [DATA_W-1:0] result,
  output logic              eq
);
  always_comb begin
    case (op)
      OP_LDI:  result = {{(DATA_W-BYTE_W){1'b0}}, imm};
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      default: result = a;
    endcase
  end

  assign eq = (a == b);

endmodule

// File: rtl/bytevm_ctrl.sv
module bytevm_ctrl
  import bytevm_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    prog_len,
  input  logic [BYTE_W-1:0]    mem_q,
  input  logic                 eq,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic [ADDR_W-1:0]    pc,
  output logic [BYTE_W-1:0]    ir,
  output logic [GPR_SEL_W-1:0] sel_a,
  output logic [GPR_SEL_W-1:0] sel_b,
  output logic                 rf_we,
  output logic                 retire,
  output logic                 halted,
  output logic                 illegal
);
  state_e            state;
  logic [BYTE_W-1:0] op1_q;
  logic              opnds_ok;
  logic              writes_reg;

  // every read targets the pre-incremented counter; data returns next cycle
  assign rd_addr = pc + ADDR_W'(1);

  assign sel_a = op1_q[GPR_SEL_W-1:0];
  assign sel_b = mem_q[GPR_SEL_W-1:0];

  assign opnds_ok   = gpr_code_ok(op1_q) && ((ir == OP_LDI) || gpr_code_ok(mem_q));
  assign writes_reg = (ir == OP_LDI) || (ir == OP_ADD) || (ir == OP_SUB);
  assign rf_we      = (state == ST_OPND2) && !start && opnds_ok && writes_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      pc      <= '0;
      ir      <= '0;
      op1_q   <= '0;
      retire  <= 1'b0;
      halted  <= 1'b0;
      illegal <= 1'b0;
    end else begin
      retire <= 1'b0;
      if (start) begin
        state   <= ST_CHECK;
        pc      <= '0;
        ir      <= '0;
        halted  <= 1'b0;
        illegal <= 1'b0;
      end else begin
        case (state)
          ST_CHECK: begin
            if (pc < prog_len) begin
              pc    <= pc + ADDR_W'(1);
              state <= ST_OPCODE;
            end else begin
              halted <= 1'b1;
              state  <= ST_HALT;
            end
          end
          ST_OPCODE: begin
            ir <= mem_q;
            if (!opcode_known(mem_q) || mem_q == OP_NOP) begin
              if (!opcode_known(mem_q)) illegal <= 1'b1;
              retire <= 1'b1;
              state  <= ST_CHECK;
            end else begin
              pc    <= pc + ADDR_W'(1);
              state <= ST_OPND1;
            end
          end
          ST_OPND1: begin
            op1_q <= mem_q;
            if (ir == OP_JMP) begin
              pc     <= ADDR_W'(mem_q);
              retire <= 1'b1;
              state  <= ST_CHECK;
            end else begin
              pc    <= pc + ADDR_W'(1);
              state <= ST_OPND2;
            end
          end
          ST_OPND2: begin
            if (!opnds_ok) illegal <= 1'b1;
            else if (ir == OP_SKE && eq) pc <= pc + ADDR_W'(3);
            retire <= 1'b1;
            state  <= ST_CHECK;
          end
          default: state <= state;
        endcase
      end
    end
  end

endmodule

// File: rtl/bytevm_core.sv
module bytevm_core
  import bytevm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] prog_len,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [7:0]        load_byte,
  output logic              halted,
  output logic              illegal,
  output logic              retire,
  output logic [ADDR_W-1:0] dbg_pc,
  output logic [7:0]        dbg_ir,
  output logic [DATA_W-1:0] dbg_reg_a,
  output logic [DATA_W-1:0] dbg_reg_b,
  output logic [DATA_W-1:0] dbg_reg_c,
  output logic [DATA_W-1:0] dbg_reg_d
);
  localparam int FLAT_W = NUM_GPR * DATA_W;

  logic [ADDR_W-1:0]    rd_addr;
  logic [BYTE_W-1:0]    mem_q;
  logic [GPR_SEL_W-1:0] sel_a;
  logic [GPR_SEL_W-1:0] sel_b;
  logic                 rf_we;
  logic [DATA_W-1:0]    opnd_a;
  logic [DATA_W-1:0]    opnd_b;
  logic [DATA_W-1:0]    alu_res;
  logic                 alu_eq;
  logic [FLAT_W-1:0]    gpr_flat;

  bytevm_progmem #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mem (
    .clk     (clk),
    .wr_en   (load_we),
    .wr_addr (load_addr),
    .wr_data (load_byte),
    .rd_addr (rd_addr),
    .rd_q    (mem_q)
  );

  bytevm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .prog_len (prog_len),
    .mem_q    (mem_q),
    .eq       (alu_eq),
    .rd_addr  (rd_addr),
    .pc       (dbg_pc),
    .ir       (dbg_ir),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .rf_we    (rf_we),
    .retire   (retire),
    .halted   (halted),
    .illegal  (illegal)
  );

  bytevm_regfile #(.DATA_W(DATA_W), .NREG(NUM_GPR)) u_rf (
    .clk      (clk),
    .rst      (rst),
    .clr      (start),
    .wr_en    (rf_we),
    .wr_sel   (sel_a),
    .wr_data  (alu_res),
    .rd_sel_a (sel_a),
    .rd_sel_b (sel_b),
    .rd_a     (opnd_a),
    .rd_b     (opnd_b),
    .flat_q   (gpr_flat)
  );

  bytevm_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (dbg_ir),
    .a      (opnd_a),
    .b      (opnd_b),
    .imm    (mem_q),
    .result (alu_res),
    .eq     (alu_eq)
  );

  assign dbg_reg_a = gpr_flat[0*DATA_W +: DATA_W];
  assign dbg_reg_b = gpr_flat[1*DATA_W +: DATA_W];
  assign dbg_reg_c = gpr_flat[2*DATA_W +: DATA_W];
  assign dbg_reg_d = gpr_flat[3*DATA_W +: DATA_W];

endmodule

// File: rtl/bytevm_checker.sv
module bytevm_checker #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [ADDR_W-1:0] prog_len,
  input logic              halted,
  input logic              illegal,
  input logic              retire,
  input logic [ADDR_W-1:0] dbg_pc,
  input logic [7:0]        dbg_ir,
  input logic [DATA_W-1:0] dbg_reg_a,
  input logic [DATA_W-1:0] dbg_reg_b,
  input logic [DATA_W-1:0] dbg_reg_c,
  input logic [DATA_W-1:0] dbg_reg_d
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!halted && !retire && !illegal && dbg_pc == '0));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (dbg_pc == '0 && dbg_reg_a == '0 && dbg_reg_b == '0 &&
               dbg_reg_c == '0 && dbg_reg_d == '0 && !halted && !illegal && !retire));

  a_r7_nop_keeps_regs: assert property (@(posedge clk) disable iff (rst)
    (retire && dbg_ir == 8'h00) |-> ($stable(dbg_reg_a) && $stable(dbg_reg_b) &&
                                     $stable(dbg_reg_c) && $stable(dbg_reg_d)));

  a_r8_halt_holds: assert property (@(posedge clk) disable iff (rst)
    (halted && !start) |=> halted);

  a_r8_quiet_when_halted: assert property (@(posedge clk) disable iff (rst)
    halted |-> !retire);

  a_r8_halt_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(halted) |-> (dbg_pc >= prog_len));

  a_r9_illegal_sticky: assert property (@(posedge clk) disable iff (rst)
    (illegal && !start) |=> illegal);

  a_r10_retire_pulse: assert property (@(posedge clk) disable iff (rst)
    retire |=> !retire);

endmodule

bind bytevm_core bytevm_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .prog_len  (prog_len),
  .halted    (halted),
  .illegal   (illegal),
  .retire    (retire),
  .dbg_pc    (dbg_pc),
  .dbg_ir    (dbg_ir),
  .dbg_reg_a (dbg_reg_a),
  .dbg_reg_b (dbg_reg_b),
  .dbg_reg_c (dbg_reg_c),
  .dbg_reg_d (dbg_reg_d)
);

// File: tb/bytevm_core_tb.sv
`timescale 1ns/1ps
module bytevm_core_tb;

  typedef struct packed {
    logic [7:0]  pc;
    logic [7:0]  ir;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] c;
    logic [15:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  prog_len = '0;
  logic        load_we = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [7:0]  load_byte = '0;
  logic        halted, illegal, retire;
  logic [7:0]  dbg_pc, dbg_ir;
  logic [15:0] dbg_reg_a, dbg_reg_b, dbg_reg_c, dbg_reg_d;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  item_t exp_q[$];
  logic [7:0]  img [256];
  logic [15:0] m_r [4];
  logic [7:0]  m_pc;
  logic        m_ill;
  logic        prev_ret = 1'b0;

  always #2 clk = ~clk;

  bytevm_core u_dut (
    .clk(clk), .rst(rst), .start(start), .prog_len(prog_len),
    .load_we(load_we), .load_addr(load_addr), .load_byte(load_byte),
    .halted(halted), .illegal(illegal), .retire(retire),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir),
    .dbg_reg_a(dbg_reg_a), .dbg_reg_b(dbg_reg_b),
    .dbg_reg_c(dbg_reg_c), .dbg_reg_d(dbg_reg_d)
  );

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  // reference interpreter built from the requirements; pushes expected retires
  task automatic model_run(input int len);
    logic [7:0]  pc, op, d, s;
    logic [15:0] r [4];
    int          guard;
    pc = '0; m_ill = 1'b0; guard = 0;
    for (int k = 0; k < 4; k++) r[k] = '0;
    while (int'(pc) < len && guard < 4000) begin
      guard++;
      pc = pc + 1; op = img[pc];
      case (op)
        8'h00: ;
        8'h01: begin
          pc = pc + 1; d = img[pc]; pc = pc + 1; s = img[pc];
          if (d < 4) r[d[1:0]] = {8'h00, s}; else m_ill = 1'b1;
        end
        8'h02, 8'h03: begin
          pc = pc + 1; d = img[pc]; pc = pc + 1; s = img[pc];
          if (d < 4 && s < 4)
            r[d[1:0]] = (op == 8'h02) ? r[d[1:0]] + r[s[1:0]] : r[d[1:0]] - r[s[1:0]];
          else m_ill = 1'b1;
        end
        8'h04: begin pc = pc + 1; pc = img[pc]; end
        8'h05: begin
          pc = pc + 1; d = img[pc]; pc = pc + 1; s = img[pc];
          if (d < 4 && s < 4) begin
            if (r[d[1:0]] == r[s[1:0]]) pc = pc + 3;
          end else m_ill = 1'b1;
        end
        default: m_ill = 1'b1;
      endcase
      exp_q.push_back(item_t'{pc, op, r[0], r[1], r[2], r[3]});
    end
    for (int k = 0; k < 4; k++) m_r[k] = r[k];
    m_pc = pc;
  endtask

  // driver: load image, build expectations, launch, wait for halt, check end state
  task automatic run_prog(input string t, input int len);
    tag = t;
    for (int i = 0; i < 256; i++) begin
      load_we = 1'b1; load_addr = 8'(i); load_byte = img[i];
      @(negedge clk);
    end
    load_we = 1'b0;
    prog_len = 8'(len);
    model_run(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({t, " R2 pc cleared by start"}, 32'(dbg_pc), 32'h0);
    chk({t, " R2 regs cleared by start"}, 32'(dbg_reg_a | dbg_reg_b | dbg_reg_c | dbg_reg_d), 32'h0);
    chk({t, " R2 flags cleared by start"}, {30'h0, halted, illegal}, 32'h0);
    for (int w = 0; w < 20000 && !halted; w++) @(negedge clk);
    chk({t, " R8 halted reached"}, 32'(halted), 32'h1);
    chk({t, " R8 final pc"}, 32'(dbg_pc), 32'(m_pc));
    chk({t, " R9 illegal flag"}, 32'(illegal), 32'(m_ill));
    chk({t, " R10 all retires seen"}, 32'(exp_q.size()), 32'h0);
    chk({t, " R4 final A"}, 32'(dbg_reg_a), 32'(m_r[0]));
    chk({t, " R4 final B"}, 32'(dbg_reg_b), 32'(m_r[1]));
    chk({t, " R4 final C"}, 32'(dbg_reg_c), 32'(m_r[2]));
    chk({t, " R4 final D"}, 32'(dbg_reg_d), 32'(m_r[3]));
    repeat (6) @(negedge clk);
    chk({t, " R8 halted stays"}, 32'(halted), 32'h1);
  endtask

  // monitor: compare every retire against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (retire) begin
        checks++;
        if (prev_ret) begin
          errors++;
          $display("FAIL %s R10 retire wider than one cycle actual=1 expected=0", tag);
        end else if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL %s R10 unexpected retire actual=pc%0h expected=none", tag, dbg_pc);
        end else begin
          item_t e, g;
          e = exp_q.pop_front();
          g = '{dbg_pc, dbg_ir, dbg_reg_a, dbg_reg_b, dbg_reg_c, dbg_reg_d};
          if (g !== e) begin
            errors++;
            $display("FAIL %s R3/R5/R6/R7 trace actual=%h expected=%h", tag, g, e);
          end
        end
      end
      prev_ret = retire;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog expired actual=running expected=halted");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) img[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state and idle without start
    chk("R1 halted low", 32'(halted), 32'h0);
    chk("R1 illegal low", 32'(illegal), 32'h0);
    chk("R1 pc zero", 32'(dbg_pc), 32'h0);
    chk("R1 regs zero", 32'(dbg_reg_a | dbg_reg_b | dbg_reg_c | dbg_reg_d), 32'h0);
    repeat (8) @(negedge clk);
    chk("R1 idle pc", 32'(dbg_pc), 32'h0);
    chk("R1 idle retire", 32'(retire), 32'h0);

    // P1 count loop: R5 jump, R6 skip on equal, R7 no-op, R3 loads
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[2] = 8'h01; img[3] = 8'h01; img[4] = 8'h05;
    img[5] = 8'h01; img[6] = 8'h02; img[7] = 8'h01;
    img[8] = 8'h02; img[9] = 8'h00; img[10] = 8'h02;
    img[11] = 8'h05; img[12] = 8'h00; img[13] = 8'h01;
    img[14] = 8'h04; img[15] = 8'h07;
    run_prog("P1", 17);
    chk("P1 R6 loop exit A", 32'(dbg_reg_a), 32'h5);
    chk("P1 R5 stop at length", 32'(dbg_pc), 32'd17);

    // P2 wrap, zero extension, unequal compare
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[1] = 8'h01; img[2] = 8'h00; img[3] = 8'h03;
    img[4] = 8'h01; img[5] = 8'h01; img[6] = 8'h05;
    img[7] = 8'h03; img[8] = 8'h00; img[9] = 8'h01;
    img[10] = 8'h01; img[11] = 8'h03; img[12] = 8'hFF;
    img[13] = 8'h02; img[14] = 8'h03; img[15] = 8'h00;
    img[16] = 8'h05; img[17] = 8'h00; img[18] = 8'h01;
    img[19] = 8'h02; img[20] = 8'h02; img[21] = 8'h02;
    run_prog("P2", 21);
    chk("P2 R4 subtract wraps", 32'(dbg_reg_a), 32'hFFFE);
    chk("P2 R3 R4 zero-extend then add wraps", 32'(dbg_reg_d), 32'h00FD);

    // P3 undefined opcode and operand codes
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[1] = 8'h09;
    img[2] = 8'h01; img[3] = 8'h07; img[4] = 8'h12;
    img[5] = 8'h01; img[6] = 8'h00; img[7] = 8'h12;
    img[8] = 8'h02; img[9] = 8'h00; img[10] = 8'h04;
    img[11] = 8'h05; img[12] = 8'h06; img[13] = 8'h00;
    img[14] = 8'h01; img[15] = 8'h01; img[16] = 8'h01;
    run_prog("P3", 16);
    chk("P3 R9 illegal set", 32'(illegal), 32'h1);
    chk("P3 R9 bad add left A", 32'(dbg_reg_a), 32'h0012);

    // P4 empty program
    run_prog("P4", 0);
    chk("P4 R8 no fetch at length zero", 32'(dbg_pc), 32'h0);

    // P5 jump beyond the program end
    for (int i = 0; i < 256; i++) img[i] = '0;
    img[1] = 8'h04; img[2] = 8'h0A;
    run_prog("P5", 4);
    chk("P5 R5 jump target loaded", 32'(dbg_pc), 32'h0A);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule